// File: doc/BRIEF.md
# Sparse Block Hierarchy Walker

This block walks a sparse matrix stored as a tree of block arrays in memory. The matrix is cut into square tiles of `SECTION` by `SECTION` elements, and only tiles that hold something are stored. Each stored tile is an array of entries, and every entry pairs a payload word with a packed in-tile position. At the lowest level (level 0) the payload is a matrix value. At every higher level the payload is a pointer to a child array one level down. Each higher-level array also carries a vector that gives the entry count of each child.

Given the root array's address, its entry count and its level, the walker performs a depth-first walk with an explicit frame stack. For every level-0 array it reaches, it emits one command to a downstream multiply unit. The command carries the array's address and length and the absolute tile coordinates. It also carries two hints: whether the result segment must be written back and replaced, and whether the multiplicand segment must be fetched again. The walker never reads leaf values. Memory is reached through a plain single-word read port.

Top module: `hsw_walker`

## Requirements
- R1: Reads use a single-word port. The walker drives `rd_en` with `rd_addr` in one cycle and takes `rd_data` in the next cycle. For an array at address P with L entries, entry i has its payload at P+2i and its position at P+2i+1. The length of its child is at P+2L+i. `rd_en` is only high while `busy` is high.
- R2: A `start` pulse while idle latches `root_ptr`, `root_len` and `top_level`, and raises `busy` on the next cycle. A `start` pulse while `busy` is high is ignored. After reset, `busy`, `done`, `err`, `leaf_valid` and `rd_en` are all low.
- R3: A position word holds the column index in bits 15:0 and the row index in bits 31:16.
- R4: The root has tile coordinates (0,0). A child's row equals the parent's row times `SECTION` plus the entry's in-tile row. The column is formed the same way.
- R5: The walk is depth-first and takes entries in array order. Each level-0 array produces one `leaf_valid` pulse that carries its address, its length and its tile row and column. When `top_level` is 0, the root itself is the single leaf, at (0,0).
- R6: `leaf_swap_res` is 1 on the first leaf after a start. After that it is 1 only when the leaf's tile row differs from the row of the previous leaf.
- R7: `leaf_load_mul` is 1 on the first leaf after a start. After that it is 1 only when the leaf's tile column differs from the column of the previous leaf.
- R8: After the root has been fully consumed, `done` pulses for exactly one cycle while `busy` is low. A root with zero entries produces `done` and no leaf.
- R9: The stack holds `DEPTH` frames, and `top_level` non-leaf levels need `top_level` frames. Pushing past `DEPTH` frames sets `err` and returns the walker to idle. In that case no further leaf and no `done` follow. `err` stays high until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (honoured only while idle) |
| root_ptr | input | 16 | Address of the root array |
| root_len | input | 16 | Entry count of the root array |
| top_level | input | 4 | Level of the root array (0 means leaf) |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory word address |
| rd_data | input | 32 | Read data, valid one cycle after `rd_en` |
| leaf_valid | output | 1 | Leaf command strobe |
| leaf_ptr | output | 16 | Leaf array address |
| leaf_len | output | 16 | Leaf array entry count |
| leaf_row | output | 32 | Absolute tile row of the leaf |
| leaf_col | output | 32 | Absolute tile column of the leaf |
| leaf_swap_res | output | 1 | Write back and replace the result segment |
| leaf_load_mul | output | 1 | Fetch the multiplicand segment again |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Stack overflow, held until the next start |

## Verification
The assertions assume a memory that answers every request exactly one cycle later. They also assume that `start` is the only input that changes the walker's course, and that the tree in memory is well formed: it is acyclic and its depth matches `top_level`. The bench holds to these assumptions. Its memory model has a fixed one-cycle latency. It builds every tree so that each child sits exactly one level below its parent, and it gives a tree more levels than the stack can hold only in the overflow test. The bench pulses `start` only at the falling clock edge, including the extra pulse that lands in the middle of a walk.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int CW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [LW-1:0] len;
        logic [LW-1:0] idx;
        logic [CW-1:0] row;
        logic [CW-1:0] col;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROOTLEAF, ST_NEXT, ST_PTR, ST_POS, ST_LEN, ST_CHILD
    } wstate_t;
endpackage

// File: rtl/hsw_frame_stack.sv
module hsw_frame_stack import hsw_pkg::*; #(
    parameter int DEPTH = 4,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  frame_t         push_frame,
    input  logic           bump,
    input  logic           pop,
    output frame_t         top,
    output logic [SPW-1:0] depth,
    output logic           full
);
    frame_t         frames_q [DEPTH];
    frame_t         frames_d [DEPTH];
    logic [SPW-1:0] sp_q, sp_d;

    always_comb begin
        frames_d = frames_q;
        sp_d     = sp_q;
        if (clr) sp_d = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (bump && !clr && sp_q == SPW'(k + 1))
                frames_d[k].idx = frames_q[k].idx + 1'b1;
        end
        if (pop && !clr && sp_q != '0) sp_d = sp_q - 1'b1;
        if (push && sp_d < SPW'(DEPTH)) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (sp_d == SPW'(k)) frames_d[k] = push_frame;
            end
            sp_d = sp_d + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
        frames_q <= frames_d;
    end

    always_comb begin
        top = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (sp_q == SPW'(k + 1)) top = frames_q[k];
        end
    end

    assign depth = sp_q;
    assign full  = (sp_q == SPW'(DEPTH));

    a_r9_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (sp_q < SPW'(DEPTH)));
    a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (sp_q != '0));
endmodule

// File: rtl/hsw_leaf_track.sv
module hsw_leaf_track import hsw_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fire,
    input  logic [CW-1:0] row,
    input  logic [CW-1:0] col,
    output logic          swap_res,
    output logic          load_mul
);
    typedef struct packed {
        logic          first;
        logic [CW-1:0] prow;
        logic [CW-1:0] pcol;
    } trk_t;

    trk_t q, d;

    always_comb begin
        d = q;
        if (clr) d.first = 1'b1;
        if (fire) begin
            d.first = 1'b0;
            d.prow  = row;
            d.pcol  = col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{first: 1'b1, prow: '0, pcol: '0};
        else        q <= d;
    end

    assign swap_res = q.first || (row != q.prow);
    assign load_mul = q.first || (col != q.pcol);

    a_r6_first_leaf_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && $past(clr) && !$past(fire)) |-> (swap_res && load_mul));
endmodule

// File: rtl/hsw_walker.sv
module hsw_walker import hsw_pkg::*; #(
    parameter int SECTION = 64,
    parameter int DEPTH   = 4,
    parameter int LVL_W   = 4,
    localparam int SPW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    root_ptr,
    input  logic [LW-1:0]    root_len,
    input  logic [LVL_W-1:0] top_level,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             leaf_valid,
    output logic [AW-1:0]    leaf_ptr,
    output logic [LW-1:0]    leaf_len,
    output logic [CW-1:0]    leaf_row,
    output logic [CW-1:0]    leaf_col,
    output logic             leaf_swap_res,
    output logic             leaf_load_mul,
    output logic             busy,
    output logic             done,
    output logic             err
);
    typedef struct packed {
        wstate_t          state;
        logic [LVL_W-1:0] tl;
        logic [AW-1:0]    cptr;
        logic [LW-1:0]    clen;
        logic [DW-1:0]    cpos;
        logic             lv;
        logic [AW-1:0]    lptr;
        logic [LW-1:0]    llen;
        logic [CW-1:0]    lrow;
        logic [CW-1:0]    lcol;
        logic             lswap;
        logic             lload;
        logic             done;
        logic             err;
    } wreg_t;

    wreg_t q, d;

    logic           s_clr, s_push, s_bump, s_pop;
    frame_t         s_frame, top;
    logic [SPW-1:0] depth;
    logic           full;
    logic           t_fire, t_swap, t_load;
    logic [CW-1:0]  c_row, c_col;
    logic [LW-1:0]  child_len;
    logic           child_is_leaf;

    hsw_frame_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .clr(s_clr), .push(s_push),
        .push_frame(s_frame), .bump(s_bump), .pop(s_pop),
        .top(top), .depth(depth), .full(full)
    );

    hsw_leaf_track u_track (
        .clk(clk), .rst_n(rst_n), .clr(s_clr), .fire(t_fire),
        .row(c_row), .col(c_col), .swap_res(t_swap), .load_mul(t_load)
    );

    assign child_len     = rd_data[LW-1:0];
    assign child_is_leaf = (int'(q.tl) == int'(depth));

    always_comb begin
        d        = q;
        d.lv     = 1'b0;
        d.done   = 1'b0;
        rd_en    = 1'b0;
        rd_addr  = '0;
        s_clr    = 1'b0;
        s_push   = 1'b0;
        s_bump   = 1'b0;
        s_pop    = 1'b0;
        s_frame  = '0;
        t_fire   = 1'b0;
        c_row    = '0;
        c_col    = '0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    s_clr  = 1'b1;
                    d.err  = 1'b0;
                    d.tl   = top_level;
                    d.cptr = root_ptr;
                    d.clen = root_len;
                    if (root_len == '0) begin
                        d.state = ST_NEXT;
                    end else if (top_level == '0) begin
                        d.state = ST_ROOTLEAF;
                    end else begin
                        s_push  = 1'b1;
                        s_frame = '{ptr: root_ptr, len: root_len, idx: '0, row: '0, col: '0};
                        d.state = ST_NEXT;
                    end
                end
            end
            ST_ROOTLEAF: begin
                t_fire  = 1'b1;
                d.lv    = 1'b1;
                d.lptr  = q.cptr;
                d.llen  = q.clen;
                d.lrow  = '0;
                d.lcol  = '0;
                d.lswap = t_swap;
                d.lload = t_load;
                d.state = ST_NEXT;
            end
            ST_NEXT: begin
                if (depth == '0) begin
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end else if (top.idx == top.len) begin
                    s_pop = 1'b1;
                end else begin
                    d.state = ST_PTR;
                end
            end
            ST_PTR: begin
                rd_en   = 1'b1;
                rd_addr = top.ptr + AW'({top.idx, 1'b0});
                d.state = ST_POS;
            end
            ST_POS: begin
                d.cptr  = rd_data[AW-1:0];
                rd_en   = 1'b1;
                rd_addr = top.ptr + AW'({top.idx, 1'b0}) + AW'(1);
                d.state = ST_LEN;
            end
            ST_LEN: begin
                d.cpos  = rd_data;
                rd_en   = 1'b1;
                rd_addr = top.ptr + AW'({top.len, 1'b0}) + AW'(top.idx);
                d.state = ST_CHILD;
            end
            ST_CHILD: begin
                c_row  = CW'(top.row * CW'(SECTION)) + CW'(q.cpos[31:16]);
                c_col  = CW'(top.col * CW'(SECTION)) + CW'(q.cpos[15:0]);
                s_bump = 1'b1;
                if (child_is_leaf) begin
                    t_fire  = 1'b1;
                    d.lv    = 1'b1;
                    d.lptr  = q.cptr;
                    d.llen  = child_len;
                    d.lrow  = c_row;
                    d.lcol  = c_col;
                    d.lswap = t_swap;
                    d.lload = t_load;
                    d.state = ST_NEXT;
                end else if (full) begin
                    d.err   = 1'b1;
                    d.state = ST_IDLE;
                end else begin
                    s_push  = 1'b1;
                    s_frame = '{ptr: q.cptr, len: child_len, idx: '0, row: c_row, col: c_col};
                    d.state = ST_NEXT;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy          = (q.state != ST_IDLE);
    assign done          = q.done;
    assign err           = q.err;
    assign leaf_valid    = q.lv;
    assign leaf_ptr      = q.lptr;
    assign leaf_len      = q.llen;
    assign leaf_row      = q.lrow;
    assign leaf_col      = q.lcol;
    assign leaf_swap_res = q.lswap;
    assign leaf_load_mul = q.lload;

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r1_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
    a_r5_leaf_busy: assert property (@(posedge clk) disable iff (!rst_n)
        leaf_valid |-> busy);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!leaf_valid && !rd_en && !done));
endmodule

// File: tb/sim_hsw_walker.sv
`timescale 1ns/1ps
module sim_hsw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] root_ptr = '0;
    logic [15:0] root_len = '0;
    logic [3:0]  top_level = '0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [31:0] rd_data = '0;
    logic        leaf_valid, leaf_swap_res, leaf_load_mul, busy, done, err;
    logic [15:0] leaf_ptr, leaf_len;
    logic [31:0] leaf_row, leaf_col;

    always #2.5 clk = ~clk;

    hsw_walker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr),
        .root_len(root_len), .top_level(top_level), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .leaf_valid(leaf_valid),
        .leaf_ptr(leaf_ptr), .leaf_len(leaf_len), .leaf_row(leaf_row),
        .leaf_col(leaf_col), .leaf_swap_res(leaf_swap_res),
        .leaf_load_mul(leaf_load_mul), .busy(busy), .done(done), .err(err)
    );

    logic [31:0] mem [0:1023];
    always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[9:0]];

    typedef struct {
        logic [15:0] ptr;
        logic [15:0] len;
        logic [31:0] row;
        logic [31:0] col;
        logic        sw;
        logic        ld;
    } leaf_t;

    leaf_t       expq[$];
    int          checks = 0;
    int          fails = 0;
    bit          done_seen = 0;
    bit          e_first;
    logic [31:0] e_prow, e_pcol;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference walk computed from the memory image (R3, R4, R5, R6, R7)
    task automatic walk(input int p, input int l, input int lvl,
                        input logic [31:0] r, input logic [31:0] c);
        if (lvl == 0) begin
            leaf_t e;
            e.ptr = p[15:0];
            e.len = l[15:0];
            e.row = r;
            e.col = c;
            e.sw  = e_first || (r != e_prow);
            e.ld  = e_first || (c != e_pcol);
            e_first = 0;
            e_prow  = r;
            e_pcol  = c;
            expq.push_back(e);
        end else begin
            for (int i = 0; i < l; i++) begin
                logic [31:0] cp, ps, cl;
                cp = mem[p + 2*i];
                ps = mem[p + 2*i + 1];
                cl = mem[p + 2*l + i];
                walk(int'(cp), int'(cl), lvl - 1,
                     r * 64 + {16'd0, ps[31:16]}, c * 64 + {16'd0, ps[15:0]});
            end
        end
    endtask

    always @(negedge clk) begin : monitor
        leaf_t e;
        if (rst_n) begin
            if (leaf_valid) begin
                if (expq.size() == 0) begin
                    chk(0, "R5", "unexpected leaf ptr", {48'd0, leaf_ptr}, 64'd0);
                end else begin
                    e = expq.pop_front();
                    chk(leaf_ptr == e.ptr && leaf_len == e.len, "R5", "leaf ptr/len",
                        {32'd0, leaf_ptr, leaf_len}, {32'd0, e.ptr, e.len});
                    chk(leaf_row == e.row && leaf_col == e.col, "R4", "leaf row/col",
                        {leaf_row, leaf_col}, {e.row, e.col});
                    chk(leaf_swap_res == e.sw, "R6", "swap_res",
                        {63'd0, leaf_swap_res}, {63'd0, e.sw});
                    chk(leaf_load_mul == e.ld, "R7", "load_mul",
                        {63'd0, leaf_load_mul}, {63'd0, e.ld});
                end
            end
            if (done) done_seen = 1;
        end
    end

    task automatic set_entry(input int base, input int l, input int i, input int cp,
                             input int r, input int c, input int cl);
        mem[base + 2*i]     = cp;
        mem[base + 2*i + 1] = {r[15:0], c[15:0]};
        mem[base + 2*l + i] = cl;
    endtask

    task automatic chain(input int base, input int n);
        for (int k = 0; k < n; k++) begin
            set_entry(base + 10*k, 1, 0, (k == n-1) ? 900 : base + 10*(k+1),
                      1, 1, (k == n-1) ? 6 : 1);
        end
    endtask

    task automatic run(input int p, input int l, input int tl,
                       input bit expect_err, input bit poke);
        int n;
        e_first = 1;
        e_prow  = '0;
        e_pcol  = '0;
        if (!expect_err && l != 0) walk(p, l, tl, 32'd0, 32'd0);
        done_seen = 0;
        @(negedge clk);
        root_ptr  = p[15:0];
        root_len  = l[15:0];
        top_level = tl[3:0];
        start     = 1;
        @(negedge clk);
        start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            root_ptr  = 16'd200;
            root_len  = 16'd3;
            top_level = 4'd1;
            start     = 1;   // R2: ignored while busy
            @(negedge clk);
            start = 0;
        end
        n = 0;
        while (!done_seen && !err && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        if (expect_err) begin
            chk(err == 1'b1, "R9", "err on overflow", {63'd0, err}, 64'd1);
            chk(done_seen == 1'b0, "R9", "no done after overflow", {63'd0, done_seen}, 64'd0);
            chk(busy == 1'b0, "R9", "idle after overflow", {63'd0, busy}, 64'd0);
        end else begin
            chk(done_seen == 1'b1, "R8", "done pulse", {63'd0, done_seen}, 64'd1);
            chk(err == 1'b0, "R9", "err clear", {63'd0, err}, 64'd0);
            chk(busy == 1'b0, "R8", "idle after done", {63'd0, busy}, 64'd0);
            chk(done == 1'b0, "R8", "done single cycle", {63'd0, done}, 64'd0);
        end
        chk(expq.size() == 0, "R5", "all leaves issued", 64'(expq.size()), 64'd0);
        expq.delete();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : driver
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        // two-level tree at 200
        set_entry(200, 3, 0, 300, 0, 1, 4);
        set_entry(200, 3, 1, 310, 0, 2, 2);
        set_entry(200, 3, 2, 320, 1, 2, 7);
        // three-level tree at 400
        set_entry(400, 2, 0, 420, 2, 3, 2);
        set_entry(400, 2, 1, 440, 2, 5, 1);
        set_entry(420, 2, 0, 600, 0, 0, 3);
        set_entry(420, 2, 1, 610, 1, 0, 1);
        set_entry(440, 1, 0, 620, 0, 0, 9);
        chain(700, 4);
        chain(740, 5);

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2 reset state
        chk(busy == 0 && done == 0 && err == 0, "R2", "reset busy/done/err",
            {61'd0, busy, done, err}, 64'd0);
        chk(leaf_valid == 0 && rd_en == 0, "R2", "reset leaf_valid/rd_en",
            {62'd0, leaf_valid, rd_en}, 64'd0);

        run(100, 5, 0, 0, 0);   // R5 root is the leaf
        run(200, 3, 1, 0, 0);   // R3 R4 R6 R7 two levels
        run(400, 2, 2, 0, 1);   // R4 three levels, R2 start ignored mid-walk
        run(400, 0, 2, 0, 0);   // R8 empty root
        run(700, 1, 4, 0, 0);   // R9 deepest chain that fits
        run(740, 1, 5, 1, 0);   // R9 overflow
        run(200, 3, 1, 0, 0);   // R9 err cleared by next start

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule